// File: doc/BRIEF.md
# ASID-Tagged Fully Associative Translation Cache

This block caches virtual-to-physical page translations for a processor memory pipeline. Every slot holds a virtual page number, an address-space identifier, a physical page number, a byte of page-table permission bits and a page-size code. A lookup compares its page number and identifier against every valid slot in the same cycle. The hit flag and the matching slot's data come back combinationally before the next clock edge. Larger pages are handled by the size code, which makes the compare skip a number of low page-number bits.

Each cycle the block decodes its three command inputs into one of four named operations: IDLE (nothing asserted), LOOKUP (`req_valid`), INSERT (`ins_valid`) and FLUSH (`flush_valid`). When more than one is asserted, FLUSH takes precedence over INSERT, which takes precedence over LOOKUP. The losing operations are dropped. An insert takes a free slot when one exists. When the cache is full it replaces the slot that has gone longest without use, judged by per-slot age stamps taken from a global sequence counter. Flushes use a zero operand as a wildcard. Six counters record reads and writes separately: accesses, hits and misses.

Top module: `asid_tlb`

## Requirements
- R1: In a LOOKUP cycle, `rsp_hit` is 1 in that same cycle when a valid slot matches both the page number (after size masking) and the identifier exactly. `rsp_ppn`, `rsp_perm` and `rsp_size` then show the lowest-index matching slot. Otherwise `rsp_hit` and the data outputs are 0.
- R2: A slot with size code s ignores the low s*9 bits of the page number when compared, so every page number inside that larger page hits it.
- R3: An INSERT whose page number and identifier match no slot exactly writes the lowest-index invalid slot whenever at least one slot is invalid. A flushed slot becomes available again.
- R4: Every lookup hit and every new fill stamps the slot with the sequence counter plus one, and the counter advances to that value. An INSERT into a full cache replaces the slot with the smallest stamp.
- R5: An INSERT whose page number and identifier equal a valid slot's exactly replaces only that slot's permission bits. Its physical page, size, stamp and all other slots are unchanged.
- R6: A FLUSH with page operand 0 and identifier operand 0 invalidates every slot.
- R7: Any other FLUSH invalidates each valid slot that matches on both operands. A page operand of 0 matches any page, and a nonzero one must equal the slot's page number after size masking. An identifier operand of 0 matches any identifier, and a nonzero one must be equal.
- R8: Each LOOKUP adds one to `rd_access` (when `req_write` is 0) or `wr_access` (when it is 1). It also adds one to the matching hit or miss counter of the same kind.
- R9: FLUSH outranks INSERT, which outranks LOOKUP. A dropped lookup gives `rsp_hit` 0 and changes no counter or stamp. A dropped insert writes no slot.
- R10: A synchronous active-high `rst` clears every valid bit, the sequence counter and all six counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request a LOOKUP |
| req_write | input | 1 | Lookup kind: 0 read, 1 write |
| req_vpn | input | VPN_W | Lookup page number |
| req_asid | input | ASID_W | Lookup address-space identifier |
| rsp_hit | output | 1 | Lookup hit this cycle |
| rsp_ppn | output | PPN_W | Physical page of the hitting slot |
| rsp_perm | output | PERM_W | Permission bits of the hitting slot |
| rsp_size | output | SZ_W | Size code of the hitting slot |
| ins_valid | input | 1 | Request an INSERT |
| ins_vpn | input | VPN_W | Page number to install |
| ins_asid | input | ASID_W | Identifier to install |
| ins_ppn | input | PPN_W | Physical page to install |
| ins_perm | input | PERM_W | Permission bits to install |
| ins_size | input | SZ_W | Size code to install |
| flush_valid | input | 1 | Request a FLUSH |
| flush_vpn | input | VPN_W | Flush page operand, 0 = any |
| flush_asid | input | ASID_W | Flush identifier operand, 0 = any |
| rd_access | output | CNT_W | Read lookups |
| rd_hit | output | CNT_W | Read lookups that hit |
| rd_miss | output | CNT_W | Read lookups that missed |
| wr_access | output | CNT_W | Write lookups |
| wr_hit | output | CNT_W | Write lookups that hit |
| wr_miss | output | CNT_W | Write lookups that missed |

## Verification
The hardest case to reach from the ports is the difference between taking a free slot and evicting the oldest one. It only appears when a hole is opened in a full cache whose stamps have been reordered by hits. The stimulus fills four slots and uses hits to reorder their ages. It then flushes one slot by identifier and inserts again. After that, lookups confirm that the slot with the smallest stamp survived, which would not happen if the insert had evicted instead of refilling the hole. Superpage masking, wildcard flushes, in-place permission updates and command collisions are each set up so that a single output lookup tells the correct behaviour apart from the likely faulty one.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE   = 2'd0,
        CMD_LOOKUP = 2'd1,
        CMD_INSERT = 2'd2,
        CMD_FLUSH  = 2'd3
    } tlb_cmd_e;

    localparam int MATCH_LOOKUP = 0;
    localparam int MATCH_EXACT  = 1;
    localparam int MATCH_FLUSH  = 2;

endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int ENTRIES  = 8,
    parameter int VPN_W    = 27,
    parameter int ASID_W   = 16,
    parameter int SZ_W     = 2,
    parameter int LVL_BITS = 9,
    parameter int MODE     = MATCH_LOOKUP
) (
    input  logic [ENTRIES-1:0]             ent_valid,
    input  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn,
    input  logic [ENTRIES-1:0][ASID_W-1:0] ent_asid,
    input  logic [ENTRIES-1:0][SZ_W-1:0]   ent_size,
    input  logic [VPN_W-1:0]               key_vpn,
    input  logic [ASID_W-1:0]              key_asid,
    output logic [ENTRIES-1:0]             match
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        logic [VPN_W-1:0] keep;
        logic             vpn_ok;
        logic             asid_ok;

        always_comb keep = {VPN_W{1'b1}} << (int'(ent_size[i]) * LVL_BITS);

        if (MODE == MATCH_EXACT) begin : g_exact
            always_comb begin
                vpn_ok  = (ent_vpn[i] == key_vpn);
                asid_ok = (ent_asid[i] == key_asid);
            end
        end else if (MODE == MATCH_FLUSH) begin : g_flush
            always_comb begin
                vpn_ok  = (key_vpn == '0) || ((ent_vpn[i] & keep) == (key_vpn & keep));
                asid_ok = (key_asid == '0) || (ent_asid[i] == key_asid);
            end
        end else begin : g_look
            always_comb begin
                vpn_ok  = ((ent_vpn[i] & keep) == (key_vpn & keep));
                asid_ok = (ent_asid[i] == key_asid);
            end
        end

        always_comb match[i] = ent_valid[i] && vpn_ok && asid_ok;
    end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 8,
    parameter int SEQ_W   = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]            valid,
    input  logic [ENTRIES-1:0][SEQ_W-1:0] stamp,
    output logic [IDX_W-1:0]              victim
);

    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] old_idx;

    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) free_idx = IDX_W'(i);
        end
    end

    always_comb begin
        old_idx = '0;
        for (int i = 1; i < ENTRIES; i++) begin
            if (stamp[i] < stamp[old_idx]) old_idx = IDX_W'(i);
        end
    end

    always_comb victim = (&valid) ? old_idx : free_idx;

endmodule

// File: rtl/tlb_stats.sv
module tlb_stats #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_en,
    input  logic             is_write,
    input  logic             hit,
    output logic [CNT_W-1:0] rd_access,
    output logic [CNT_W-1:0] rd_hit,
    output logic [CNT_W-1:0] rd_miss,
    output logic [CNT_W-1:0] wr_access,
    output logic [CNT_W-1:0] wr_hit,
    output logic [CNT_W-1:0] wr_miss
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_access <= '0;
            rd_hit    <= '0;
            rd_miss   <= '0;
            wr_access <= '0;
            wr_hit    <= '0;
            wr_miss   <= '0;
        end else if (acc_en) begin
            if (is_write) begin
                wr_access <= wr_access + ONE;
                if (hit) wr_hit  <= wr_hit + ONE;
                else     wr_miss <= wr_miss + ONE;
            end else begin
                rd_access <= rd_access + ONE;
                if (hit) rd_hit  <= rd_hit + ONE;
                else     rd_miss <= rd_miss + ONE;
            end
        end
    end

    // R8
    rd_sum_chk: assert property (@(posedge clk) disable iff (rst)
        rd_access == rd_hit + rd_miss);

    // R8
    wr_sum_chk: assert property (@(posedge clk) disable iff (rst)
        wr_access == wr_hit + wr_miss);

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES  = 8,
    parameter int VPN_W    = 27,
    parameter int ASID_W   = 16,
    parameter int PPN_W    = 44,
    parameter int PERM_W   = 8,
    parameter int SZ_W     = 2,
    parameter int LVL_BITS = 9,
    parameter int SEQ_W    = 32,
    parameter int CNT_W    = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [ASID_W-1:0] req_asid,
    output logic              rsp_hit,
    output logic [PPN_W-1:0]  rsp_ppn,
    output logic [PERM_W-1:0] rsp_perm,
    output logic [SZ_W-1:0]   rsp_size,
    input  logic              ins_valid,
    input  logic [VPN_W-1:0]  ins_vpn,
    input  logic [ASID_W-1:0] ins_asid,
    input  logic [PPN_W-1:0]  ins_ppn,
    input  logic [PERM_W-1:0] ins_perm,
    input  logic [SZ_W-1:0]   ins_size,
    input  logic              flush_valid,
    input  logic [VPN_W-1:0]  flush_vpn,
    input  logic [ASID_W-1:0] flush_asid,
    output logic [CNT_W-1:0]  rd_access,
    output logic [CNT_W-1:0]  rd_hit,
    output logic [CNT_W-1:0]  rd_miss,
    output logic [CNT_W-1:0]  wr_access,
    output logic [CNT_W-1:0]  wr_hit,
    output logic [CNT_W-1:0]  wr_miss
);

    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0]             valid_q;
    logic [SEQ_W-1:0]               seq_q;
    logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
    logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
    logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;
    logic [ENTRIES-1:0][PERM_W-1:0] perm_q;
    logic [ENTRIES-1:0][SZ_W-1:0]   size_q;
    logic [ENTRIES-1:0][SEQ_W-1:0]  stamp_q;

    tlb_cmd_e           cmd;
    logic [ENTRIES-1:0] look_vec, dup_vec, flush_vec;
    logic [IDX_W-1:0]   look_idx, dup_idx, vic_idx;
    logic               look_any, dup_any;
    logic [SEQ_W-1:0]   seq_next;

    function automatic logic [IDX_W-1:0] lowest_set(input logic [ENTRIES-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

    always_comb begin
        if (flush_valid)    cmd = CMD_FLUSH;
        else if (ins_valid) cmd = CMD_INSERT;
        else if (req_valid) cmd = CMD_LOOKUP;
        else                cmd = CMD_IDLE;
    end

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .SZ_W(SZ_W),
                .LVL_BITS(LVL_BITS), .MODE(MATCH_LOOKUP)) u_look (
        .ent_valid(valid_q), .ent_vpn(vpn_q), .ent_asid(asid_q), .ent_size(size_q),
        .key_vpn(req_vpn), .key_asid(req_asid), .match(look_vec));

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .SZ_W(SZ_W),
                .LVL_BITS(LVL_BITS), .MODE(MATCH_EXACT)) u_dup (
        .ent_valid(valid_q), .ent_vpn(vpn_q), .ent_asid(asid_q), .ent_size(size_q),
        .key_vpn(ins_vpn), .key_asid(ins_asid), .match(dup_vec));

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .SZ_W(SZ_W),
                .LVL_BITS(LVL_BITS), .MODE(MATCH_FLUSH)) u_flush (
        .ent_valid(valid_q), .ent_vpn(vpn_q), .ent_asid(asid_q), .ent_size(size_q),
        .key_vpn(flush_vpn), .key_asid(flush_asid), .match(flush_vec));

    tlb_victim #(.ENTRIES(ENTRIES), .SEQ_W(SEQ_W)) u_victim (
        .valid(valid_q), .stamp(stamp_q), .victim(vic_idx));

    always_comb begin
        look_any = |look_vec;
        dup_any  = |dup_vec;
        look_idx = lowest_set(look_vec);
        dup_idx  = lowest_set(dup_vec);
        seq_next = seq_q + SEQ_W'(1);
    end

    // Output process: lookup response
    always_comb begin
        rsp_hit  = (cmd == CMD_LOOKUP) && look_any;
        rsp_ppn  = rsp_hit ? ppn_q[look_idx]  : '0;
        rsp_perm = rsp_hit ? perm_q[look_idx] : '0;
        rsp_size = rsp_hit ? size_q[look_idx] : '0;
    end

    // State process: valid bits and sequence counter
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            seq_q   <= '0;
        end else begin
            unique case (cmd)
                CMD_LOOKUP: if (look_any) seq_q <= seq_next;
                CMD_INSERT: if (!dup_any) begin
                    valid_q[vic_idx] <= 1'b1;
                    seq_q            <= seq_next;
                end
                CMD_FLUSH:  valid_q <= valid_q & ~flush_vec;
                default: ;
            endcase
        end
    end

    // Slot payload and age stamps
    always_ff @(posedge clk) begin
        unique case (cmd)
            CMD_LOOKUP: if (look_any) stamp_q[look_idx] <= seq_next;
            CMD_INSERT: begin
                if (dup_any) begin
                    perm_q[dup_idx] <= ins_perm;
                end else begin
                    vpn_q[vic_idx]   <= ins_vpn;
                    asid_q[vic_idx]  <= ins_asid;
                    ppn_q[vic_idx]   <= ins_ppn;
                    perm_q[vic_idx]  <= ins_perm;
                    size_q[vic_idx]  <= ins_size;
                    stamp_q[vic_idx] <= seq_next;
                end
            end
            default: ;
        endcase
    end

    tlb_stats #(.CNT_W(CNT_W)) u_stats (
        .clk(clk), .rst(rst), .acc_en(cmd == CMD_LOOKUP), .is_write(req_write),
        .hit(look_any), .rd_access(rd_access), .rd_hit(rd_hit), .rd_miss(rd_miss),
        .wr_access(wr_access), .wr_hit(wr_hit), .wr_miss(wr_miss));

    // R4
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (seq_q == $past(seq_q)) || (seq_q == $past(seq_q) + SEQ_W'(1)));

    // R6
    flush_all_chk: assert property (@(posedge clk) disable iff (rst)
        (flush_valid && flush_vpn == '0 && flush_asid == '0) |=> (valid_q == '0));

    // R3
    fill_grow_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_INSERT && !dup_any && !(&valid_q))
        |=> ($countones(valid_q) == $past($countones(valid_q)) + 1));

    // R5
    dup_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_INSERT && dup_any) |=> $stable(valid_q) && $stable(seq_q));

    // R9
    flush_wins_chk: assert property (@(posedge clk) disable iff (rst)
        flush_valid |=> $stable(seq_q));

    // R10
    rst_clear_chk: assert property (@(posedge clk)
        $fell(rst) |-> (valid_q == '0) && (seq_q == '0));

endmodule

// File: tb/asid_tlb_bench.sv
module asid_tlb_bench;

    localparam int ENTRIES = 4;
    localparam int VPN_W   = 27;
    localparam int ASID_W  = 16;
    localparam int PPN_W   = 44;
    localparam int PERM_W  = 8;
    localparam int SZ_W    = 2;
    localparam int CNT_W   = 32;

    localparam logic [1:0] LK = 2'd0, IN = 2'd1, FL = 2'd2;

    typedef struct packed {
        logic [1:0]        op;
        logic              wr;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PPN_W-1:0]  ppn;
        logic [PERM_W-1:0] perm;
        logic [SZ_W-1:0]   sz;
        logic              eh;
        logic [PPN_W-1:0]  ep;
        logic [PERM_W-1:0] eperm;
    } vec_t;

    localparam int NV = 35;
    localparam vec_t VEC [NV] = '{
        '{LK, 1'b0, 27'h100,  16'd1, 44'h0,  8'h00, 2'd0, 1'b0, 44'h0,  8'h00}, // 0 R1 cold miss
        '{IN, 1'b0, 27'h100,  16'd1, 44'hA,  8'h0F, 2'd0, 1'b0, 44'h0,  8'h00},
        '{IN, 1'b0, 27'h200,  16'd1, 44'hB,  8'h0F, 2'd0, 1'b0, 44'h0,  8'h00},
        '{IN, 1'b0, 27'h300,  16'd2, 44'hC,  8'h0F, 2'd0, 1'b0, 44'h0,  8'h00},
        '{IN, 1'b0, 27'h400,  16'd2, 44'hD,  8'h0F, 2'd0, 1'b0, 44'h0,  8'h00},
        '{LK, 1'b0, 27'h100,  16'd1, 44'h0,  8'h00, 2'd0, 1'b1, 44'hA,  8'h0F}, // 5 R1 hit
        '{LK, 1'b1, 27'h200,  16'd2, 44'h0,  8'h00, 2'd0, 1'b0, 44'h0,  8'h00}, // R1 wrong id
        '{IN, 1'b0, 27'h500,  16'd1, 44'hE,  8'h0F, 2'd0, 1'b0, 44'h0,  8'h00}, // R4 evict 0x200
        '{LK, 1'b0, 27'h200,  16'd1, 44'h0,  8'h00, 2'd0, 1'b0, 44'h0,  8'h00},
        '{LK, 1'b0, 27'h500,  16'd1, 44'h0,  8'h00, 2'd0, 1'b1, 44'hE,  8'h0F},
        '{LK, 1'b1, 27'h300,  16'd2, 44'h0,  8'h00, 2'd0, 1'b1, 44'hC,  8'h0F}, // 10
        '{IN, 1'b0, 27'h600,  16'd3, 44'hF,  8'h0F, 2'd0, 1'b0, 44'h0,  8'h00}, // R4 evict 0x400
        '{LK, 1'b0, 27'h400,  16'd2, 44'h0,  8'h00, 2'd0, 1'b0, 44'h0,  8'h00},
        '{IN, 1'b0, 27'h100,  16'd1, 44'h77, 8'h5B, 2'd0, 1'b0, 44'h0,  8'h00}, // R5 update
        '{LK, 1'b0, 27'h100,  16'd1, 44'h0,  8'h00, 2'd0, 1'b1, 44'hA,  8'h5B},
        '{FL, 1'b0, 27'h0,    16'd2, 44'h0,  8'h00, 2'd0, 1'b0, 44'h0,  8'h00}, // 15 R7 by id
        '{LK, 1'b1, 27'h300,  16'd2, 44'h0,  8'h00, 2'd0, 1'b0, 44'h0,  8'h00},
        '{IN, 1'b0, 27'h700,  16'd1, 44'h7,  8'h0F, 2'd0, 1'b0, 44'h0,  8'h00}, // R3 reuse hole
        '{LK, 1'b0, 27'h500,  16'd1, 44'h0,  8'h00, 2'd0, 1'b1, 44'hE,  8'h0F},
        '{LK, 1'b0, 27'h100,  16'd1, 44'h0,  8'h00, 2'd0, 1'b1, 44'hA,  8'h5B},
        '{LK, 1'b1, 27'h600,  16'd3, 44'h0,  8'h00, 2'd0, 1'b1, 44'hF,  8'h0F}, // 20
        '{LK, 1'b0, 27'h700,  16'd1, 44'h0,  8'h00, 2'd0, 1'b1, 44'h7,  8'h0F},
        '{FL, 1'b0, 27'h500,  16'd0, 44'h0,  8'h00, 2'd0, 1'b0, 44'h0,  8'h00}, // R7 by page
        '{LK, 1'b0, 27'h500,  16'd1, 44'h0,  8'h00, 2'd0, 1'b0, 44'h0,  8'h00},
        '{FL, 1'b0, 27'h700,  16'd3, 44'h0,  8'h00, 2'd0, 1'b0, 44'h0,  8'h00}, // R7 id mismatch
        '{LK, 1'b0, 27'h700,  16'd1, 44'h0,  8'h00, 2'd0, 1'b1, 44'h7,  8'h0F}, // 25
        '{FL, 1'b0, 27'h700,  16'd1, 44'h0,  8'h00, 2'd0, 1'b0, 44'h0,  8'h00}, // R7 both
        '{LK, 1'b1, 27'h700,  16'd1, 44'h0,  8'h00, 2'd0, 1'b0, 44'h0,  8'h00},
        '{IN, 1'b0, 27'h1200, 16'd4, 44'h33, 8'h0F, 2'd1, 1'b0, 44'h0,  8'h00}, // R2 superpage
        '{LK, 1'b0, 27'h12AB, 16'd4, 44'h0,  8'h00, 2'd0, 1'b1, 44'h33, 8'h0F},
        '{LK, 1'b0, 27'h1400, 16'd4, 44'h0,  8'h00, 2'd0, 1'b0, 44'h0,  8'h00}, // 30
        '{LK, 1'b0, 27'h600,  16'd3, 44'h0,  8'h00, 2'd0, 1'b1, 44'hF,  8'h0F},
        '{FL, 1'b0, 27'h0,    16'd0, 44'h0,  8'h00, 2'd0, 1'b0, 44'h0,  8'h00}, // R6 all
        '{LK, 1'b0, 27'h600,  16'd3, 44'h0,  8'h00, 2'd0, 1'b0, 44'h0,  8'h00},
        '{LK, 1'b1, 27'h12AB, 16'd4, 44'h0,  8'h00, 2'd0, 1'b0, 44'h0,  8'h00}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0, req_write = 1'b0;
    logic [VPN_W-1:0]  req_vpn = '0;
    logic [ASID_W-1:0] req_asid = '0;
    logic              rsp_hit;
    logic [PPN_W-1:0]  rsp_ppn;
    logic [PERM_W-1:0] rsp_perm;
    logic [SZ_W-1:0]   rsp_size;
    logic              ins_valid = 1'b0;
    logic [VPN_W-1:0]  ins_vpn = '0;
    logic [ASID_W-1:0] ins_asid = '0;
    logic [PPN_W-1:0]  ins_ppn = '0;
    logic [PERM_W-1:0] ins_perm = '0;
    logic [SZ_W-1:0]   ins_size = '0;
    logic              flush_valid = 1'b0;
    logic [VPN_W-1:0]  flush_vpn = '0;
    logic [ASID_W-1:0] flush_asid = '0;
    logic [CNT_W-1:0]  rd_access, rd_hit, rd_miss, wr_access, wr_hit, wr_miss;

    int tests = 0;
    int fails = 0;
    int e_ra = 0, e_rh = 0, e_rm = 0, e_wa = 0, e_wh = 0, e_wm = 0;

    always #2 clk = ~clk;

    asid_tlb #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PPN_W(PPN_W),
               .PERM_W(PERM_W), .SZ_W(SZ_W), .CNT_W(CNT_W)) u_asid_tlb (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_vpn(req_vpn), .req_asid(req_asid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn),
        .rsp_perm(rsp_perm), .rsp_size(rsp_size), .ins_valid(ins_valid),
        .ins_vpn(ins_vpn), .ins_asid(ins_asid), .ins_ppn(ins_ppn), .ins_perm(ins_perm),
        .ins_size(ins_size), .flush_valid(flush_valid), .flush_vpn(flush_vpn),
        .flush_asid(flush_asid), .rd_access(rd_access), .rd_hit(rd_hit),
        .rd_miss(rd_miss), .wr_access(wr_access), .wr_hit(wr_hit), .wr_miss(wr_miss));

    task automatic check(input logic ok, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic check_counters(input string tag);
        check(rd_access == CNT_W'(e_ra), {tag, " R8 rd_access"}, 64'(rd_access), 64'(e_ra));
        check(rd_hit    == CNT_W'(e_rh), {tag, " R8 rd_hit"},    64'(rd_hit),    64'(e_rh));
        check(rd_miss   == CNT_W'(e_rm), {tag, " R8 rd_miss"},   64'(rd_miss),   64'(e_rm));
        check(wr_access == CNT_W'(e_wa), {tag, " R8 wr_access"}, 64'(wr_access), 64'(e_wa));
        check(wr_hit    == CNT_W'(e_wh), {tag, " R8 wr_hit"},    64'(wr_hit),    64'(e_wh));
        check(wr_miss   == CNT_W'(e_wm), {tag, " R8 wr_miss"},   64'(wr_miss),   64'(e_wm));
    endtask

    task automatic idle_inputs();
        req_valid = 1'b0; ins_valid = 1'b0; flush_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic do_lookup(input logic wr, input logic [VPN_W-1:0] v,
                             input logic [ASID_W-1:0] a, input logic eh,
                             input logic [PPN_W-1:0] ep, input logic [PERM_W-1:0] eperm,
                             input string tag);
        @(negedge clk);
        idle_inputs();
        req_valid = 1'b1; req_write = wr; req_vpn = v; req_asid = a;
        #1;
        check(rsp_hit == eh, {tag, " R1 hit"}, 64'(rsp_hit), 64'(eh));
        if (eh) begin
            check(rsp_ppn == ep, {tag, " R1 ppn"}, 64'(rsp_ppn), 64'(ep));
            check(rsp_perm == eperm, {tag, " R5 perm"}, 64'(rsp_perm), 64'(eperm));
        end
        if (wr) begin e_wa++; if (eh) e_wh++; else e_wm++; end
        else    begin e_ra++; if (eh) e_rh++; else e_rm++; end
    endtask

    task automatic do_insert(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                             input logic [PPN_W-1:0] p, input logic [PERM_W-1:0] pm,
                             input logic [SZ_W-1:0] s);
        @(negedge clk);
        idle_inputs();
        ins_valid = 1'b1; ins_vpn = v; ins_asid = a; ins_ppn = p; ins_perm = pm; ins_size = s;
    endtask

    task automatic do_flush(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a);
        @(negedge clk);
        idle_inputs();
        flush_valid = 1'b1; flush_vpn = v; flush_asid = a;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R10 reset state
        check_counters("reset");
        do_lookup(1'b0, 27'h100, 16'd1, 1'b0, '0, '0, "reset lookup R10");

        // Table walk: R1 R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                LK: do_lookup(VEC[i].wr, VEC[i].vpn, VEC[i].asid, VEC[i].eh,
                              VEC[i].ep, VEC[i].eperm, $sformatf("vec%0d", i));
                IN: do_insert(VEC[i].vpn, VEC[i].asid, VEC[i].ppn, VEC[i].perm, VEC[i].sz);
                default: do_flush(VEC[i].vpn, VEC[i].asid);
            endcase
        end
        @(negedge clk);
        idle_inputs();
        #1;
        check_counters("table");

        // R9: insert and lookup together, lookup dropped
        do_insert(27'h900, 16'd5, 44'h99, 8'h0F, 2'd0);
        @(negedge clk);
        idle_inputs();
        ins_valid = 1'b1; ins_vpn = 27'hA00; ins_asid = 16'd5; ins_ppn = 44'hAA;
        ins_perm = 8'h0F; ins_size = 2'd0;
        req_valid = 1'b1; req_vpn = 27'h900; req_asid = 16'd5;
        #1;
        check(rsp_hit == 1'b0, "R9 dropped lookup hit", 64'(rsp_hit), 64'd0);
        @(negedge clk);
        idle_inputs();
        #1;
        check_counters("R9 dropped lookup");

        // R9: flush and insert together, insert dropped
        @(negedge clk);
        idle_inputs();
        flush_valid = 1'b1; flush_vpn = 27'h900; flush_asid = 16'd5;
        ins_valid = 1'b1; ins_vpn = 27'hB00; ins_asid = 16'd5; ins_ppn = 44'hBB;
        do_lookup(1'b0, 27'hB00, 16'd5, 1'b0, '0, '0, "R9 dropped insert");
        do_lookup(1'b0, 27'h900, 16'd5, 1'b0, '0, '0, "R9 flush applied");
        do_lookup(1'b1, 27'hA00, 16'd5, 1'b1, 44'hAA, 8'h0F, "R9 insert kept");

        // R10: reset in the middle of a run
        @(negedge clk);
        idle_inputs();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        e_ra = 0; e_rh = 0; e_rm = 0; e_wa = 0; e_wh = 0; e_wm = 0;
        #1;
        check_counters("R10 midrun");
        do_lookup(1'b1, 27'hA00, 16'd5, 1'b0, '0, '0, "R10 entries cleared");
        @(negedge clk);
        idle_inputs();
        #1;
        check_counters("R10 after");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule